// File: doc/BRIEF.md
# Tick Event Down-Counter Timer

This block is a decrementing interval timer that gives an operating-system scheduler a regular interrupt source, so that a processor can sleep between scheduling points. It counts down by one on each pulse of a divided slow tick enable, the same enable the calendar counter uses. The prescaler that produces that enable lives outside the block.

Software writes a value into a separate reload register and then pulses a set strobe, which copies that value into the live counter. The live count can be read back at any time and is kept apart from the programmed value. A mode input picks between two behaviours. In one-shot mode the counter fires once and then stops at zero. In auto-reload mode it refills itself from the reload register each time it fires.

Each event sets a pending flag that software clears by writing one. The interrupt line is the pending flag gated by an interrupt enable, and that enable comes out of reset set.

Top module: `tick_event_timer`

## Requirements
- R1: After reset the live count is 0, the pending flag is 0, the interrupt enable is 1 and the interrupt line is 0.
- R2: A set strobe copies the reload value into the live count on the next clock edge. The strobe takes priority over a tick arriving in the same cycle.
- R3: While the run enable is 1 and a tick pulse is present, a live count above 1 decreases by exactly one. The count is held in any cycle that has no tick pulse, and in any cycle where the run enable is 0.
- R4: An event happens on a tick with run enable 1 while the live count is 1. The pending flag reads 1 from the next cycle onward.
- R5: In one-shot mode (mode input 0), the live count goes to 0 at the event. It then stays at 0 and raises no further events until a new set strobe.
- R6: In auto-reload mode (mode input 1), the event loads the live count with the current reload value instead of 0.
- R7: A live count of 0 never produces an event, whatever the mode, the run enable or the ticks.
- R8: A clear pulse with pending 1 drops the pending flag on the next cycle. A clear in the same cycle as a new event leaves the flag at 1.
- R9: The interrupt line equals the pending flag AND the interrupt enable. The interrupt enable is written through a write strobe and data bit.
- R10: Changing the reload value does not change the live count until the next set strobe or auto-reload event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_pulse_i | input | 1 | Divided slow tick enable, one cycle wide |
| run_en_i | input | 1 | Counting enable |
| auto_mode_i | input | 1 | 0 = one-shot, 1 = auto-reload |
| reload_val_i | input | 32 | Programmed reload value |
| set_i | input | 1 | Copy reload value into the live count |
| stat_clr_i | input | 1 | Write-one-to-clear pulse for the pending flag |
| ien_wr_i | input | 1 | Write strobe for the interrupt enable |
| ien_wdata_i | input | 1 | Data written to the interrupt enable |
| count_o | output | 32 | Live count readback |
| pending_o | output | 1 | Event pending flag |
| ien_o | output | 1 | Interrupt enable readback |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is driven through several input patterns, and each one separates a different failure.
- A tick stream that has gaps, and cycles with the run enable low, separates counting on every clock from counting on ticks alone.
- A one-shot run that keeps receiving ticks after expiry shows whether the counter stops at zero or wraps.
- An auto-reload run, with the reload value changed mid-count, shows whether the refill takes the current reload value and whether the live count is kept separate from it.
- The corner cases are these: a zero load, a set strobe together with a tick, a clear that collides with a new event, and the interrupt enable masking a pending flag that stays set.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   localparam int unsigned TICK_CNT_W = 32;

   typedef enum logic {
      TMODE_ONESHOT = 1'b0,
      TMODE_RELOAD  = 1'b1
   } tick_mode_e;
endpackage

// File: rtl/tick_dcnt_core.sv
module tick_dcnt_core #(
   parameter int unsigned CNT_W       = 32,
   parameter bit          RELOAD_SUPP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_pulse_i,
   input  logic             run_en_i,
   input  logic             auto_mode_i,
   input  logic [CNT_W-1:0] reload_val_i,
   input  logic             set_i,
   output logic [CNT_W-1:0] count_o,
   output logic             event_o
);
   import tick_timer_pkg::*;

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             step;
   logic             at_one;
   tick_mode_e       mode_eff;

   generate
      if (RELOAD_SUPP) begin : g_mode_full
         assign mode_eff = tick_mode_e'(auto_mode_i);
      end else begin : g_mode_oneshot
         assign mode_eff = TMODE_ONESHOT;
      end
   endgenerate

   assign step    = tick_pulse_i & run_en_i & ~set_i & (cnt_q != CNT_ZERO);
   assign at_one  = (cnt_q == CNT_ONE);
   assign event_o = step & at_one;

   always_comb begin
      cnt_d = cnt_q;
      if (set_i) begin
         cnt_d = reload_val_i;
      end else if (step) begin
         if (at_one) begin
            cnt_d = (mode_eff == TMODE_RELOAD) ? reload_val_i : CNT_ZERO;
         end else begin
            cnt_d = cnt_q - CNT_ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/tick_evt_flag.sv
module tick_evt_flag #(
   parameter bit IEN_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic stat_clr_i,
   input  logic ien_wr_i,
   input  logic ien_wdata_i,
   output logic pending_o,
   output logic ien_o,
   output logic irq_o
);
   logic pend_q;
   logic ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (event_i) begin
         pend_q <= 1'b1;
      end else if (stat_clr_i) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= IEN_RST;
      end else if (ien_wr_i) begin
         ien_q <= ien_wdata_i;
      end
   end

   assign pending_o = pend_q;
   assign ien_o     = ien_q;
   assign irq_o     = pend_q & ien_q;
endmodule

// File: rtl/tick_event_timer.sv
module tick_event_timer #(
   parameter int unsigned CNT_W       = tick_timer_pkg::TICK_CNT_W,
   parameter bit          RELOAD_SUPP = 1'b1,
   parameter bit          IEN_RST     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_pulse_i,
   input  logic             run_en_i,
   input  logic             auto_mode_i,
   input  logic [CNT_W-1:0] reload_val_i,
   input  logic             set_i,
   input  logic             stat_clr_i,
   input  logic             ien_wr_i,
   input  logic             ien_wdata_i,
   output logic [CNT_W-1:0] count_o,
   output logic             pending_o,
   output logic             ien_o,
   output logic             irq_o
);
   logic evt;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tick_event_timer: CNT_W must be at least 2");
      end
   endgenerate

   tick_dcnt_core #(
      .CNT_W       (CNT_W),
      .RELOAD_SUPP (RELOAD_SUPP)
   ) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_pulse_i (tick_pulse_i),
      .run_en_i     (run_en_i),
      .auto_mode_i  (auto_mode_i),
      .reload_val_i (reload_val_i),
      .set_i        (set_i),
      .count_o      (count_o),
      .event_o      (evt)
   );

   tick_evt_flag #(
      .IEN_RST (IEN_RST)
   ) u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .event_i     (evt),
      .stat_clr_i  (stat_clr_i),
      .ien_wr_i    (ien_wr_i),
      .ien_wdata_i (ien_wdata_i),
      .pending_o   (pending_o),
      .ien_o       (ien_o),
      .irq_o       (irq_o)
   );
endmodule

// File: rtl/tick_event_timer_chk.sv
module tick_event_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_pulse_i,
   input logic             run_en_i,
   input logic             auto_mode_i,
   input logic [CNT_W-1:0] reload_val_i,
   input logic             set_i,
   input logic             stat_clr_i,
   input logic [CNT_W-1:0] count_o,
   input logic             pending_o,
   input logic             ien_o,
   input logic             irq_o
);
   logic adv;
   assign adv = tick_pulse_i & run_en_i & ~set_i;

   // R2
   set_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (count_o == $past(reload_val_i)));

   // R3
   dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && count_o > CNT_W'(1)) |=> (count_o == $past(count_o) - CNT_W'(1)));

   // R3
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !(tick_pulse_i && run_en_i)) |=> $stable(count_o));

   // R4
   event_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && count_o == CNT_W'(1)) |=> pending_o);

   // R5
   oneshot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !auto_mode_i && count_o == CNT_W'(1)) |=> (count_o == '0));

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && auto_mode_i && count_o == CNT_W'(1)) |=> (count_o == $past(reload_val_i)));

   // R7
   zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && count_o == '0) |=> (count_o == '0));

   // R8
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && !stat_clr_i) |=> pending_o);

   // R9
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_o || !pending_o) |-> !irq_o);
endmodule

bind tick_event_timer tick_event_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_pulse_i (tick_pulse_i),
   .run_en_i     (run_en_i),
   .auto_mode_i  (auto_mode_i),
   .reload_val_i (reload_val_i),
   .set_i        (set_i),
   .stat_clr_i   (stat_clr_i),
   .count_o      (count_o),
   .pending_o    (pending_o),
   .ien_o        (ien_o),
   .irq_o        (irq_o)
);

// File: tb/tick_event_timer_tb.sv
module tick_event_timer_tb;
   localparam int W  = 32;
   localparam int NV = 17;
   localparam int VW = 5 + W + W + 1;

   // vector fields: set, run, tick, mode, clr, reload, exp_count, exp_pending
   localparam logic [VW-1:0] VEC [NV] = '{
      {5'b10000, 32'd3, 32'd3, 1'b0},  // R2 load 3
      {5'b01100, 32'd3, 32'd2, 1'b0},  // R3 decrement
      {5'b01000, 32'd3, 32'd2, 1'b0},  // R3 no tick holds
      {5'b00100, 32'd3, 32'd2, 1'b0},  // R3 disabled holds
      {5'b01100, 32'd3, 32'd1, 1'b0},  // R3
      {5'b01100, 32'd3, 32'd0, 1'b1},  // R4 R5 one-shot event
      {5'b01100, 32'd3, 32'd0, 1'b1},  // R5 stays at zero
      {5'b00001, 32'd3, 32'd0, 1'b0},  // R8 clear
      {5'b10010, 32'd2, 32'd2, 1'b0},  // R2 load 2
      {5'b01110, 32'd5, 32'd1, 1'b0},  // R10 reload change ignored
      {5'b01110, 32'd5, 32'd5, 1'b1},  // R6 auto-reload takes new value
      {5'b01011, 32'd5, 32'd5, 1'b0},  // R8 clear
      {5'b10010, 32'd0, 32'd0, 1'b0},  // R2 load 0
      {5'b01110, 32'd0, 32'd0, 1'b0},  // R7 zero, auto mode
      {5'b01100, 32'd0, 32'd0, 1'b0},  // R7 zero, one-shot
      {5'b11100, 32'd1, 32'd1, 1'b0},  // R2 set beats tick
      {5'b01101, 32'd1, 32'd0, 1'b1}   // R8 clear collides with event
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_pulse_i = 1'b0, run_en_i = 1'b0, auto_mode_i = 1'b0;
   logic [W-1:0] reload_val_i = '0;
   logic         set_i = 1'b0, stat_clr_i = 1'b0, ien_wr_i = 1'b0, ien_wdata_i = 1'b0;
   logic [W-1:0] count_o;
   logic         pending_o, ien_o, irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tick_event_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_pulse_i(tick_pulse_i), .run_en_i(run_en_i),
      .auto_mode_i(auto_mode_i), .reload_val_i(reload_val_i), .set_i(set_i),
      .stat_clr_i(stat_clr_i), .ien_wr_i(ien_wr_i), .ien_wdata_i(ien_wdata_i),
      .count_o(count_o), .pending_o(pending_o), .ien_o(ien_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      {set_i, run_en_i, tick_pulse_i, stat_clr_i, ien_wr_i} = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 count", count_o, '0);
      check("R1 pending", W'(pending_o), '0);
      check("R1 ien", W'(ien_o), W'(1));
      check("R1 irq", W'(irq_o), '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         {set_i, run_en_i, tick_pulse_i, auto_mode_i, stat_clr_i} = VEC[i][VW-1 -: 5];
         reload_val_i = VEC[i][W+W : W+1];
         step();
         check($sformatf("vec%0d count", i), count_o, VEC[i][W:1]);
         check($sformatf("vec%0d pending", i), W'(pending_o), W'(VEC[i][0]));
      end
      idle_inputs();

      // R9 irq follows pending and enable
      check("R9 irq on", W'(irq_o), W'(1));
      ien_wr_i = 1'b1; ien_wdata_i = 1'b0;
      step();
      ien_wr_i = 1'b0;
      check("R9 ien cleared", W'(ien_o), '0);
      check("R9 irq masked", W'(irq_o), '0);
      check("R9 pending kept", W'(pending_o), W'(1));
      ien_wr_i = 1'b1; ien_wdata_i = 1'b1;
      step();
      ien_wr_i = 1'b0;
      check("R9 irq restored", W'(irq_o), W'(1));

      // R1 reset mid-run restores defaults
      ien_wr_i = 1'b1; ien_wdata_i = 1'b0; set_i = 1'b1; reload_val_i = 32'hDEAD_BEEF;
      step();
      idle_inputs();
      check("R2 large load", count_o, 32'hDEAD_BEEF);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 count after reset", count_o, '0);
      check("R1 ien after reset", W'(ien_o), W'(1));
      check("R1 pending after reset", W'(pending_o), '0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule